// File: doc/BRIEF.md
# Bus-mapped UART register bridge with byte streams

This block gives a processor the register view of a classic 16550-style UART over a 32-bit Wishbone slave port with byte selects. There is no serial line and no bit timing. Bytes the processor writes to the transmit holding register are queued and leave on a valid/ready byte stream toward on-chip logic. Bytes arriving on a second valid/ready stream are queued and read from the receive buffer register. The divisor latch pair is stored and read back but drives nothing.

The registers are packed as byte lanes into two bus words. Every access is acknowledged one cycle after the request, whether or not the receive buffer holds data, so a driver that polls or reads blindly never stalls the bus. A single interrupt output reports received data and an empty transmit buffer, each under its own enable, with received data taking priority in the identification code.

Top module: `wb_uart_regs`

## Requirements
- R1: Every request (cyc and stb high) is acknowledged in the next cycle with a one-cycle ack pulse; read data appears only in the byte lanes that are selected, and all other lanes read zero.
- R2: After reset, the interrupt-enable register reads 0x00, the line-control register reads 0x00, the line-status register reads 0x60, irq, ack and tx_valid_o are low and rx_ready_o is high.
- R3: At word address 0x0, lane 3 (bits 31:24) is the receive buffer on read and transmit holding register on write, lane 2 (bits 23:16) is the interrupt-enable register (bits 3:0 stored, bits 7:4 read zero), lane 1 (bits 15:8) is interrupt identification on read and FIFO control on write, lane 0 (bits 7:0) is line control; at word address 0x4 lane 2 is line status, and writes at 0x4 change nothing.
- R4: Line-status bit 0 is set while the receive buffer holds a byte; bits 5 and 6 are both set while the transmit buffer is empty; all other bits read zero.
- R5: FIFO-control bit 0 sets the FIFO-enabled flag, which makes identification bits 7:6 read 0b11 (0b00 when clear); identification bits 3:0 read 0x4 when received data is pending and enabled, else 0x2 when the transmit buffer is empty and that interrupt is enabled, else 0x1.
- R6: Writing FIFO-control bit 1 empties the receive buffer and bit 2 empties the transmit buffer.
- R7: While line-control bit 7 is set, lane 3 and lane 2 at address 0x0 access the low and high divisor bytes; these accesses neither queue a transmit byte nor remove a received byte.
- R8: With interrupt-enable bit 0 set, irq is high in the cycle after a byte is accepted on the receive stream and low in the cycle after the last buffered byte is read.
- R9: With interrupt-enable bit 1 set, irq is high while the transmit buffer is empty, drops when a byte is written, rises when that byte leaves on the transmit stream, and drops when the enable is cleared.
- R10: A receive-buffer read while the buffer is empty returns 0x00 and is acknowledged like any other access.
- R11: A transmit write while the transmit buffer holds DEPTH bytes is dropped; rx_ready_o is low while the receive buffer holds DEPTH bytes.
- R12: Both directions keep strict first-in first-out order across long interleaved traffic with random gaps and backpressure.
- R13: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Byte address; bit 2 picks the register word |
| wb_sel_i | input | 4 | Byte-lane selects |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ack |
| wb_ack_o | output | 1 | Acknowledge |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_ready_i | input | 1 | Sink accepts outgoing byte |
| rx_data_i | input | 8 | Incoming byte |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_ready_o | output | 1 | Block accepts incoming byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong buffer count shows at the ports in the very next cycle, as a line-status bit, tx_valid_o, rx_ready_o or irq that disagrees with the number of bytes pushed and popped so far. A wrong read or write pointer stays hidden until the affected byte is delivered, and then shows as a byte out of order on the transmit stream or in a receive-buffer read, which the long interleaved run exposes. A wrong lane decode or divisor-latch switch shows in the same access as wrong read data or as an unexpected byte on the transmit stream.

// File: rtl/wb_uart_regs.sv
module wb_uart_regs #(
  parameter int DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic [2:0]  wb_adr_i,
  input  logic [3:0]  wb_sel_i,
  input  logic [31:0] wb_dat_i,
  output logic [31:0] wb_dat_o,
  output logic        wb_ack_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  output logic        rx_ready_o,
  output logic        irq_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          ack_q, fifo_en;
  logic [31:0]   rdat_q, rd_word;
  logic [3:0]    ier;
  logic [7:0]    lcr, dll, dlm;

  wire req    = wb_cyc_i & wb_stb_i & ~ack_q;
  wire page   = wb_adr_i[2];
  wire dlab   = lcr[7];
  wire wr0    = req & wb_we_i & ~page;
  wire rd0    = req & ~wb_we_i & ~page;
  wire thr_wr = wr0 & wb_sel_i[3] & ~dlab;
  wire rbr_rd = rd0 & wb_sel_i[3] & ~dlab;
  wire fcr_wr = wr0 & wb_sel_i[1];
  wire rx_flush = fcr_wr & wb_dat_i[9];
  wire tx_flush = fcr_wr & wb_dat_i[10];

  wire tx_empty = (tx_cnt == '0);
  wire tx_full  = (tx_cnt == FULL);
  wire rx_empty = (rx_cnt == '0);
  wire rx_full  = (rx_cnt == FULL);

  wire tx_push = thr_wr & ~tx_full;
  wire tx_pop  = tx_valid_o & tx_ready_i;
  wire rx_push = rx_valid_i & rx_ready_o;
  wire rx_pop  = rbr_rd & ~rx_empty;

  wire unused_ok = ^{wb_adr_i[1:0], wb_dat_i[23:20], wb_dat_i[15:11]};

  wire [7:0] lsr = {1'b0, tx_empty, tx_empty, 4'b0, ~rx_empty};
  wire [3:0] iid = (ier[0] & ~rx_empty) ? 4'h4 :
                   (ier[1] &  tx_empty) ? 4'h2 : 4'h1;
  wire [7:0] iir = {{2{fifo_en}}, 2'b00, iid};

  assign irq_o      = (iid != 4'h1);
  assign tx_valid_o = ~tx_empty;
  assign tx_data_o  = tx_mem[tx_rp];
  assign rx_ready_o = ~rx_full;
  assign wb_ack_o   = ack_q;
  assign wb_dat_o   = rdat_q;

  always_comb begin
    if (page)
      rd_word = {8'h00, wb_sel_i[2] ? lsr : 8'h00, 16'h0000};
    else
      rd_word = {wb_sel_i[3] ? (dlab ? dll : (rx_empty ? 8'h00 : rx_mem[rx_rp])) : 8'h00,
                 wb_sel_i[2] ? (dlab ? dlm : {4'h0, ier}) : 8'h00,
                 wb_sel_i[1] ? iir : 8'h00,
                 wb_sel_i[0] ? lcr : 8'h00};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ack_q   <= 1'b0;
      rdat_q  <= '0;
      ier     <= '0;
      lcr     <= '0;
      dll     <= '0;
      dlm     <= '0;
      fifo_en <= 1'b0;
    end else begin
      ack_q  <= req;
      rdat_q <= (req & ~wb_we_i) ? rd_word : '0;
      if (wr0 & wb_sel_i[3] & dlab)  dll <= wb_dat_i[31:24];
      if (wr0 & wb_sel_i[2] & dlab)  dlm <= wb_dat_i[23:16];
      if (wr0 & wb_sel_i[2] & ~dlab) ier <= wb_dat_i[19:16];
      if (wr0 & wb_sel_i[0])         lcr <= wb_dat_i[7:0];
      if (fcr_wr)                    fifo_en <= wb_dat_i[8];
    end
  end

  always_ff @(posedge clk_i) begin
    if (tx_push) tx_mem[tx_wp] <= wb_dat_i[31:24];
    if (rx_push) rx_mem[rx_wp] <= rx_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || tx_flush) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || rx_flush) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  assert_ack_next_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    req |=> wb_ack_o);
  assert_ack_pulse_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    wb_ack_o |=> !wb_ack_o);
  assert_rx_seen_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (rx_push & ~rx_flush) |=> (lsr[0] && !rx_empty));
  assert_thr_visible_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (thr_wr & tx_empty & ~tx_flush) |=> tx_valid_o);
  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (tx_cnt <= FULL) && (rx_cnt <= FULL));
  assert_tx_hold_R13: assert property (@(posedge clk_i) disable iff (rst_i)
    (tx_valid_o & ~tx_ready_i & ~tx_flush) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: tb/sim_wb_uart_regs.sv
module sim_wb_uart_regs;
  localparam int DEPTH = 16;
  localparam int N = 1000;
  localparam int NV = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc = 0, stb = 0, we = 0;
  logic [2:0] adr = '0;
  logic [3:0] sel = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic ack;
  logic [7:0] tx_data, rx_data = '0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, irq;

  int nchk = 0, nfail = 0;
  bit bg_on = 0, rx_hs = 0;
  int rx_idx = 0, tx_seen = 0;

  always #2.5 clk = ~clk;

  wb_uart_regs #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .irq_o(irq));

  // {we, adr, sel, wdat, expected read}
  localparam logic [71:0] VEC [NV] = '{
    {1'b0, 3'd0, 4'h4, 32'h0, 32'h0000_0000},        // R2 IER reset
    {1'b0, 3'd0, 4'h1, 32'h0, 32'h0000_0000},        // R2 LCR reset
    {1'b0, 3'd4, 4'h4, 32'h0, 32'h0060_0000},        // R2 LSR reset
    {1'b1, 3'd0, 4'h4, 32'h0003_0000, 32'h0},
    {1'b0, 3'd0, 4'h4, 32'h0, 32'h0003_0000},        // R3 IER stored
    {1'b0, 3'd0, 4'h2, 32'h0, 32'h0000_0200},        // R5 FIFOs off, tx empty id
    {1'b1, 3'd0, 4'h2, 32'h0000_0100, 32'h0},
    {1'b0, 3'd0, 4'h2, 32'h0, 32'h0000_C200},        // R5 FIFOs on
    {1'b1, 3'd0, 4'h4, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 3'd0, 4'h4, 32'h0, 32'h000F_0000},        // R3 upper IER bits zero
    {1'b1, 3'd0, 4'h4, 32'h0, 32'h0},
    {1'b0, 3'd0, 4'h2, 32'h0, 32'h0000_C100},        // R5 no interrupt id
    {1'b1, 3'd0, 4'h1, 32'h0000_0080, 32'h0},
    {1'b1, 3'd0, 4'h8, 32'h0100_0000, 32'h0},
    {1'b1, 3'd0, 4'h4, 32'h0000_0000, 32'h0},
    {1'b0, 3'd0, 4'h8, 32'h0, 32'h0100_0000},        // R7 low divisor
    {1'b0, 3'd0, 4'h4, 32'h0, 32'h0000_0000},        // R7 high divisor
    {1'b0, 3'd0, 4'h1, 32'h0, 32'h0000_0080},        // R3 LCR stored
    {1'b0, 3'd0, 4'hF, 32'h0, 32'h0100_C180},        // R1 all lanes
    {1'b1, 3'd0, 4'h1, 32'h0, 32'h0},
    {1'b0, 3'd4, 4'hF, 32'h0, 32'h0060_0000},        // R1 unused lanes zero
    {1'b1, 3'd4, 4'hF, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 3'd4, 4'h4, 32'h0, 32'h0060_0000},        // R3 LSR read-only
    {1'b0, 3'd0, 4'h8, 32'h0, 32'h0000_0000}         // R10 empty read
  };

  function automatic logic [7:0] rxpat(int k); return 8'(k * 37 + 5); endfunction
  function automatic logic [7:0] txpat(int k); return 8'(k * 53 + 11); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [2:0] a, input logic [3:0] s,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; sel = s; wdat = d;
    @(negedge clk);
    chk("R1 ack after one cycle", {31'b0, ack}, 32'h1);
    q = rdat;
    cyc = 0; stb = 0; we = 0; sel = '0; wdat = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] s, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, a, s, d, q);
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin : rx_source
    wait (bg_on);
    while (rx_idx < N) begin
      @(negedge clk);
      if (rx_hs) begin rx_idx++; rx_valid = 0; rx_hs = 0; end
      if (!rx_valid && rx_idx < N && ($urandom % 4 == 0)) begin
        rx_valid = 1; rx_data = rxpat(rx_idx);
      end
      #1;
      rx_hs = rx_valid && rx_ready;
    end
    rx_valid = 0;
  end

  initial begin : tx_sink
    wait (bg_on);
    while (tx_seen < N) begin
      @(negedge clk);
      tx_ready = ($urandom % 3 != 0);
      #1;
      if (tx_valid && tx_ready) begin
        chk("R12 transmit order", {24'h0, tx_data}, {24'h0, txpat(tx_seen)});
        tx_seen++;
      end
    end
    tx_ready = 0;
  end

  initial begin : main
    logic [31:0] q;
    int sent, got;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R2 irq after reset", {31'b0, irq}, 32'h0);
    chk("R2 ack after reset", {31'b0, ack}, 32'h0);
    chk("R2 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
    chk("R2 rx_ready after reset", {31'b0, rx_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][71], VEC[i][70:68], VEC[i][67:64], VEC[i][63:32], q);
      if (!VEC[i][71]) chk($sformatf("table[%0d] R3 read data", i), q, VEC[i][31:0]);
    end

    // R8 receive interrupt
    wr(3'd0, 4'h4, 32'h0001_0000);
    chk("R8 irq idle", {31'b0, irq}, 32'h0);
    push_rx(8'h3C);
    chk("R8 irq on byte", {31'b0, irq}, 32'h1);
    bus(1'b0, 3'd4, 4'h4, 32'h0, q);
    chk("R4 data ready and tx empty", q, 32'h0061_0000);
    bus(1'b0, 3'd0, 4'h2, 32'h0, q);
    chk("R5 rx id has priority", q, 32'h0000_C400);
    bus(1'b0, 3'd0, 4'h8, 32'h0, q);
    chk("R8 byte read", q, 32'h3C00_0000);
    chk("R8 irq after read", {31'b0, irq}, 32'h0);

    // R9 transmit interrupt and R13 hold
    wr(3'd0, 4'h4, 32'h0002_0000);
    chk("R9 irq on enable", {31'b0, irq}, 32'h1);
    wr(3'd0, 4'h8, 32'h5A00_0000);
    chk("R9 irq after write", {31'b0, irq}, 32'h0);
    chk("R9 tx_valid", {31'b0, tx_valid}, 32'h1);
    bus(1'b0, 3'd4, 4'h4, 32'h0, q);
    chk("R4 tx not empty", q, 32'h0000_0000);
    repeat (3) @(negedge clk);
    chk("R13 data held", {23'h0, tx_valid, tx_data}, 32'h0000_015A);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    chk("R9 tx drained", {31'b0, tx_valid}, 32'h0);
    chk("R9 irq after drain", {31'b0, irq}, 32'h1);
    wr(3'd0, 4'h4, 32'h0000_0000);
    chk("R9 irq after disable", {31'b0, irq}, 32'h0);

    // R7 divisor latch access leaves buffers alone
    wr(3'd0, 4'h1, 32'h0000_0080);
    wr(3'd0, 4'h8, 32'h7700_0000);
    chk("R7 no tx byte", {31'b0, tx_valid}, 32'h0);
    push_rx(8'h11);
    bus(1'b0, 3'd0, 4'h8, 32'h0, q);
    chk("R7 divisor read", q, 32'h7700_0000);
    bus(1'b0, 3'd4, 4'h4, 32'h0, q);
    chk("R7 rx byte kept", q, 32'h0061_0000);
    wr(3'd0, 4'h1, 32'h0000_0000);
    bus(1'b0, 3'd0, 4'h8, 32'h0, q);
    chk("R7 rx byte after", q, 32'h1100_0000);

    // R11 full buffers
    for (int k = 0; k <= DEPTH; k++) wr(3'd0, 4'h8, {8'(8'h80 + k), 24'h0});
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      chk("R11 tx drain order", {23'h0, tx_valid, tx_data}, {23'h0, 1'b1, 8'(8'h80 + k)});
      tx_ready = 1;
    end
    @(negedge clk);
    tx_ready = 0;
    chk("R11 extra write dropped", {31'b0, tx_valid}, 32'h0);
    for (int k = 0; k < DEPTH; k++) push_rx(8'(8'h40 + k));
    chk("R11 rx_ready low when full", {31'b0, rx_ready}, 32'h0);
    push_rx(8'hEE);
    for (int k = 0; k < DEPTH; k++) begin
      bus(1'b0, 3'd0, 4'h8, 32'h0, q);
      chk("R11 rx order", q, {8'(8'h40 + k), 24'h0});
    end
    bus(1'b0, 3'd4, 4'h4, 32'h0, q);
    chk("R11 extra rx byte refused", q, 32'h0060_0000);

    // R6 flushes
    push_rx(8'h01); push_rx(8'h02); push_rx(8'h03);
    wr(3'd0, 4'h8, 32'hA100_0000);
    wr(3'd0, 4'h8, 32'hA200_0000);
    wr(3'd0, 4'h2, 32'h0000_0700);
    chk("R6 tx flushed", {31'b0, tx_valid}, 32'h0);
    bus(1'b0, 3'd4, 4'h4, 32'h0, q);
    chk("R6 rx flushed", q, 32'h0060_0000);
    bus(1'b0, 3'd0, 4'h2, 32'h0, q);
    chk("R5 FIFOs still enabled", q, 32'h0000_C100);
    wr(3'd0, 4'h2, 32'h0000_0000);
    bus(1'b0, 3'd0, 4'h2, 32'h0, q);
    chk("R5 FIFOs disabled", q, 32'h0000_0100);

    // R12 interleaved streams
    bg_on = 1;
    sent = 0; got = 0;
    while (sent < N || got < N) begin
      if ($urandom % 2) begin
        if (sent < N) begin
          bus(1'b0, 3'd4, 4'h4, 32'h0, q);
          if (q[21]) begin
            wr(3'd0, 4'h8, {txpat(sent), 24'h0});
            sent++;
          end
        end
      end else if (got < N) begin
        bus(1'b0, 3'd4, 4'h4, 32'h0, q);
        if (q[16]) begin
          bus(1'b0, 3'd0, 4'h8, 32'h0, q);
          chk("R12 receive order", q, {rxpat(got), 24'h0});
          got++;
        end
      end
    end
    wait (tx_seen == N);
    @(negedge clk);
    finish_up();
  end
endmodule